// File: doc/BRIEF.md
# Two-Wire Byte Memory Slave with Read Pointer

This block is a two-wire (I2C) bus slave that fronts a 256-byte array. A master addresses it with a 7-bit device address and a direction bit. In the write direction, the first byte after the address sets an internal pointer and any further bytes are stored at that pointer. In the read direction the slave returns bytes starting at the pointer. A master reaches any location by a short write that carries only the byte address, followed by a repeated START in the read direction. Reading continues for as long as the master acknowledges each byte.

SCL and SDA are sampled by the system clock through synchronisers. SDA is driven only through an output enable that pulls the line low. The pointer survives between transactions. It always points one past the last byte read or written, and it rolls over from the top of the array to zero.

Top module: `i2c_mem_rd_slave`

## Requirements
- R1: START is SDA falling while SCL is high. STOP is SDA rising while SCL is high. Either one abandons any transfer in progress, and after a STOP the slave keeps SDA released until the next START.
- R2: The first byte after START carries the device address in bits 7..1 and the direction in bit 0 (1 = read). When bits 7..1 equal the `DEV_ADDR` parameter, the slave pulls SDA low during the ninth clock.
- R3: When the device address does not match, the slave gives no acknowledge. It never drives SDA and changes neither memory nor pointer until the next START.
- R4: In the write direction, the byte after the device address loads the pointer. Each later byte is stored at the pointer, after which the pointer advances by one. Every one of these bytes is acknowledged.
- R5: A read-direction address with no preceding byte address returns the byte at the current pointer and advances the pointer.
- R6: A write-direction address and byte address, followed by a repeated START with a read-direction address, returns the byte at the newly loaded address.
- R7: After each data byte the slave releases SDA for the ninth clock. If the master pulls SDA low there, the slave sends the byte at the next address.
- R8: The pointer advances from 255 to 0. This applies to both reads and writes, and data keeps flowing across the rollover.
- R9: If the master leaves SDA high after a data byte, the read ends. The slave keeps SDA released until the next START or STOP.
- R10: Data is sent most significant bit first. A 1 is sent by releasing SDA. The slave changes its SDA drive only while SCL is low.
- R11: While reset is held, SDA is released.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level |
| sda_oe | output | 1 | 1 pulls SDA low, 0 releases it |

## Verification
The assertions check on every cycle the properties that hold regardless of the traffic. The slave's SDA drive changes only while SCL is low. Any pointer advance is exactly plus one, with rollover to zero. The slave is silent while ignoring the bus, after a STOP, and after a master's not-acknowledge. Whether the returned bytes are the right ones can only be shown by the bench's scenarios. These cover random versus current-address starting points, sequences that run across the 255-to-0 rollover, a pointer left behind by an address-only write ended with STOP, and traffic after a foreign address that must leave memory and pointer untouched.

// File: rtl/i2cm_pkg.sv
package i2cm_pkg;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_DEV,
    PH_BADDR,
    PH_WDATA,
    PH_READ,
    PH_WAIT
  } phase_t;

  // true when the received address byte selects this device
  function automatic logic addr_hit(input logic [7:0] rx, input logic [6:0] dev);
    return rx[7:1] == dev;
  endfunction

endpackage

// File: rtl/i2cm_sync.sv
module i2cm_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_lvl,
  output logic sda_lvl,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);

  logic [1:0] raw;
  logic [1:0] lvl;
  logic [1:0] prv;

  assign raw = {sda_i, scl_i};

  // one synchroniser chain per line; the extra top stage holds the previous level
  for (genvar g = 0; g < 2; g++) begin : g_line
    logic [STAGES:0] pipe;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pipe <= '1;
      else        pipe <= {pipe[STAGES-1:0], raw[g]};
    end
    assign lvl[g] = pipe[STAGES-1];
    assign prv[g] = pipe[STAGES];
  end

  assign scl_lvl   = lvl[0];
  assign sda_lvl   = lvl[1];
  assign scl_rise  = lvl[0] & ~prv[0];
  assign scl_fall  = ~lvl[0] & prv[0];
  assign start_det = lvl[0] & prv[0] & prv[1] & ~lvl[1];
  assign stop_det  = lvl[0] & prv[0] & ~prv[1] & lvl[1];

endmodule

// File: rtl/i2cm_mem.sv
module i2cm_mem #(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [7:0]        wdata,
  input  logic [ADDR_W-1:0] raddr,
  output logic [7:0]        rdata
);

  localparam int DEPTH = 1 << ADDR_W;

  logic [7:0] cells [DEPTH];

  always_ff @(posedge clk) begin
    if (we) cells[waddr] <= wdata;
  end

  assign rdata = cells[raddr];

endmodule

// File: rtl/i2cm_ctrl.sv
module i2cm_ctrl
  import i2cm_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR = 7'h50,
  parameter int         ADDR_W   = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_lvl,
  input  logic              sda_lvl,
  input  logic              scl_rise,
  input  logic              scl_fall,
  input  logic              start_det,
  input  logic              stop_det,
  input  logic [7:0]        mem_rdata,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_waddr,
  output logic [7:0]        mem_wdata,
  output logic [ADDR_W-1:0] mem_raddr,
  output logic              sda_oe
);

  localparam logic [3:0] BITS = 4'd8;

  function automatic logic [ADDR_W-1:0] ptr_inc(input logic [ADDR_W-1:0] p);
    return p + 1'b1;
  endfunction

  phase_t            phase;
  logic [3:0]        bitcnt;
  logic              ack_ph;
  logic [7:0]        rx_sh;
  logic [7:0]        tx_sh;
  logic              rw_q;
  logic              mack_q;
  logic [ADDR_W-1:0] ptr;
  logic              oe_q;

  // named events
  logic rx_phase, byte_done, ack_end, tx_done, mack_end, addr_ok;
  logic load_tx, wr_fire, ptr_adv;

  assign rx_phase  = (phase == PH_DEV) || (phase == PH_BADDR) || (phase == PH_WDATA);
  assign byte_done = rx_phase && scl_fall && (bitcnt == BITS) && !ack_ph;
  assign ack_end   = rx_phase && scl_fall && ack_ph;
  assign tx_done   = (phase == PH_READ) && scl_fall && (bitcnt == BITS) && !ack_ph;
  assign mack_end  = (phase == PH_READ) && scl_fall && ack_ph;
  assign addr_ok   = addr_hit(rx_sh, DEV_ADDR);
  assign load_tx   = (ack_end && (phase == PH_DEV) && rw_q) || (mack_end && mack_q);
  assign wr_fire   = byte_done && (phase == PH_WDATA);
  assign ptr_adv   = load_tx || wr_fire;

  assign mem_we    = wr_fire;
  assign mem_waddr = ptr;
  assign mem_wdata = rx_sh;
  assign mem_raddr = ptr;
  assign sda_oe    = oe_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase  <= PH_IDLE;
      bitcnt <= '0;
      ack_ph <= 1'b0;
      rx_sh  <= '0;
      tx_sh  <= '0;
      rw_q   <= 1'b0;
      mack_q <= 1'b0;
      ptr    <= '0;
      oe_q   <= 1'b0;
    end else if (start_det) begin
      phase  <= PH_DEV;
      bitcnt <= '0;
      ack_ph <= 1'b0;
      oe_q   <= 1'b0;
    end else if (stop_det) begin
      phase  <= PH_IDLE;
      bitcnt <= '0;
      ack_ph <= 1'b0;
      oe_q   <= 1'b0;
    end else begin
      unique case (phase)
        PH_DEV, PH_BADDR, PH_WDATA: begin
          if (scl_rise && !ack_ph && (bitcnt < BITS)) begin
            rx_sh  <= {rx_sh[6:0], sda_lvl};
            bitcnt <= bitcnt + 4'd1;
          end
          if (byte_done) begin
            if (phase == PH_DEV) begin
              if (addr_ok) begin
                oe_q   <= 1'b1;
                ack_ph <= 1'b1;
                rw_q   <= rx_sh[0];
              end else begin
                phase  <= PH_WAIT;
              end
            end else begin
              if (phase == PH_BADDR) ptr <= rx_sh[ADDR_W-1:0];
              else                   ptr <= ptr_inc(ptr);
              oe_q   <= 1'b1;
              ack_ph <= 1'b1;
            end
          end
          if (ack_end) begin
            ack_ph <= 1'b0;
            bitcnt <= '0;
            oe_q   <= 1'b0;
            if (phase == PH_DEV) begin
              if (rw_q) begin
                phase <= PH_READ;
                tx_sh <= mem_rdata;
                oe_q  <= ~mem_rdata[7];
                ptr   <= ptr_inc(ptr);
              end else begin
                phase <= PH_BADDR;
              end
            end else begin
              phase <= PH_WDATA;
            end
          end
        end
        PH_READ: begin
          if (scl_rise) begin
            if (ack_ph)                bitcnt <= bitcnt;
            else if (bitcnt < BITS)    bitcnt <= bitcnt + 4'd1;
            if (ack_ph) mack_q <= ~sda_lvl;
          end
          if (scl_fall) begin
            if (!ack_ph && (bitcnt < BITS)) begin
              tx_sh <= {tx_sh[6:0], 1'b0};
              oe_q  <= ~tx_sh[6];
            end else if (tx_done) begin
              oe_q   <= 1'b0;
              ack_ph <= 1'b1;
            end else if (mack_end) begin
              ack_ph <= 1'b0;
              bitcnt <= '0;
              if (mack_q) begin
                tx_sh <= mem_rdata;
                oe_q  <= ~mem_rdata[7];
                ptr   <= ptr_inc(ptr);
              end else begin
                phase <= PH_WAIT;
                oe_q  <= 1'b0;
              end
            end
          end
        end
        default: begin
          oe_q <= 1'b0;
        end
      endcase
    end
  end

  // R10: drive changes only while the clock line is low (bus conditions excepted)
  a_r10_oe_scl_low: assert property (@(posedge clk) disable iff (!rst_n)
    ((oe_q != $past(oe_q)) && !$past(start_det) && !$past(stop_det)) |-> !scl_lvl);

  // R4 / R7: every pointer advance is exactly one step
  a_r4_ptr_step: assert property (@(posedge clk) disable iff (!rst_n)
    ptr_adv |=> (ptr == $past(ptr) + ADDR_W'(1)));

  // R8: top of the array rolls to zero
  a_r8_ptr_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (ptr_adv && (ptr == '1)) |=> (ptr == '0));

  // R3: silent while ignoring the bus
  a_r3_wait_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_WAIT) |-> !oe_q);

  // R1: a STOP parks the slave with SDA released
  a_r1_stop_idle: assert property (@(posedge clk) disable iff (!rst_n)
    stop_det |=> ((phase == PH_IDLE) && !oe_q));

  // R9: master's not-acknowledge ends the read
  a_r9_nack_release: assert property (@(posedge clk) disable iff (!rst_n)
    (mack_end && !mack_q && !start_det && !stop_det) |=> ((phase == PH_WAIT) && !oe_q));

endmodule

// File: rtl/i2c_mem_rd_slave.sv
module i2c_mem_rd_slave #(
  parameter logic [6:0] DEV_ADDR    = 7'h50,
  parameter int         ADDR_W      = 8,
  parameter int         SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_oe
);

  logic              scl_lvl, sda_lvl, scl_rise, scl_fall, start_det, stop_det;
  logic              mem_we;
  logic [ADDR_W-1:0] mem_waddr, mem_raddr;
  logic [7:0]        mem_wdata, mem_rdata;

  i2cm_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk       (clk),
    .rst_n     (rst_n),
    .scl_i     (scl_i),
    .sda_i     (sda_i),
    .scl_lvl   (scl_lvl),
    .sda_lvl   (sda_lvl),
    .scl_rise  (scl_rise),
    .scl_fall  (scl_fall),
    .start_det (start_det),
    .stop_det  (stop_det)
  );

  i2cm_mem #(.ADDR_W(ADDR_W)) u_mem (
    .clk   (clk),
    .we    (mem_we),
    .waddr (mem_waddr),
    .wdata (mem_wdata),
    .raddr (mem_raddr),
    .rdata (mem_rdata)
  );

  i2cm_ctrl #(.DEV_ADDR(DEV_ADDR), .ADDR_W(ADDR_W)) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .scl_lvl   (scl_lvl),
    .sda_lvl   (sda_lvl),
    .scl_rise  (scl_rise),
    .scl_fall  (scl_fall),
    .start_det (start_det),
    .stop_det  (stop_det),
    .mem_rdata (mem_rdata),
    .mem_we    (mem_we),
    .mem_waddr (mem_waddr),
    .mem_wdata (mem_wdata),
    .mem_raddr (mem_raddr),
    .sda_oe    (sda_oe)
  );

endmodule

// File: tb/test_i2c_mem_rd_slave.sv
module test_i2c_mem_rd_slave;

  localparam logic [6:0] DEV = 7'h50;
  localparam int         Q   = 5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl_m = 1'b1;
  logic sda_m = 1'b1;
  logic sda_oe;
  logic sda_line;

  always #4 clk = ~clk;

  assign sda_line = sda_m & ~sda_oe;

  i2c_mem_rd_slave #(.DEV_ADDR(DEV)) i_i2c_mem_rd_slave (
    .clk    (clk),
    .rst_n  (rst_n),
    .scl_i  (scl_m),
    .sda_i  (sda_line),
    .sda_oe (sda_oe)
  );

  // behavioural reference: byte store and pointer
  int         mem_m [256];
  int         ptr_m = 0;
  logic [7:0] wq [$];

  int n_cmp = 0;
  int n_bad = 0;
  bit exp_quiet = 1'b0;
  bit mon_on = 1'b0;
  bit finished = 1'b0;

  task automatic chk(input string rq, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: got %0h expected %0h", rq, act, exp);
    end
  endtask

  // every clock: the slave must not pull SDA when the model says it is silent (R1, R3, R9)
  always @(negedge clk) begin
    if (mon_on && exp_quiet && !finished) begin
      n_cmp++;
      if (sda_oe) begin
        n_bad++;
        $display("FAIL R1/R3/R9 quiet: got sda_oe=%0d expected 0 at %0t", sda_oe, $time);
      end
    end
  end

  task automatic wait_q();
    repeat (Q) @(negedge clk);
  endtask

  task automatic put_bit(input logic b);
    sda_m = b; wait_q();
    scl_m = 1'b1; wait_q(); wait_q();
    scl_m = 1'b0; wait_q();
  endtask

  task automatic get_bit(output logic b);
    sda_m = 1'b1; wait_q();
    scl_m = 1'b1; wait_q();
    b = sda_line; wait_q();
    scl_m = 1'b0; wait_q();
  endtask

  task automatic bus_start();
    sda_m = 1'b1; wait_q();
    scl_m = 1'b1; wait_q();
    sda_m = 1'b0; wait_q();
    scl_m = 1'b0; wait_q();
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; wait_q();
    scl_m = 1'b1; wait_q();
    sda_m = 1'b1; wait_q();
  endtask

  task automatic send_byte(input logic [7:0] b, output logic acked);
    logic x;
    for (int i = 7; i >= 0; i--) put_bit(b[i]);
    get_bit(x);
    acked = ~x;
  endtask

  task automatic recv_byte(input logic give_ack, output logic [7:0] b);
    logic x;
    for (int i = 7; i >= 0; i--) begin
      get_bit(x);
      b[i] = x;
    end
    put_bit(~give_ack);
  endtask

  // write-direction transfer: byte address then the bytes held in wq
  task automatic wr_txn(input logic [7:0] a);
    logic ak;
    exp_quiet = 1'b0;
    bus_start();
    send_byte({DEV, 1'b0}, ak); chk("R2 write address ack", ak, 1);
    send_byte(a, ak);           chk("R4 byte address ack", ak, 1);
    ptr_m = a;
    foreach (wq[k]) begin
      send_byte(wq[k], ak);     chk("R4 data ack", ak, 1);
      mem_m[ptr_m] = wq[k];
      ptr_m = (ptr_m + 1) % 256;
    end
    bus_stop();
    exp_quiet = 1'b1;
    wait_q();
  endtask

  // read transfer of n bytes; random=1 adds the dummy write
  task automatic rd_txn(input bit random, input logic [7:0] a, input int n, input string rq);
    logic ak;
    logic [7:0] got;
    exp_quiet = 1'b0;
    bus_start();
    if (random) begin
      send_byte({DEV, 1'b0}, ak); chk("R6 dummy write ack", ak, 1);
      send_byte(a, ak);           chk("R6 byte address ack", ak, 1);
      ptr_m = a;
      bus_start();
    end
    send_byte({DEV, 1'b1}, ak);   chk("R2 read address ack", ak, 1);
    for (int k = 0; k < n; k++) begin
      recv_byte(k < n - 1, got);
      chk(rq, got, mem_m[ptr_m]);
      ptr_m = (ptr_m + 1) % 256;
    end
    exp_quiet = 1'b1;             // R9: silent after the not-acknowledge
    put_bit(1'b1);
    put_bit(1'b0);
    bus_stop();
    wait_q();
  endtask

  initial begin
    logic ak;
    logic [7:0] got;
    repeat (10) @(negedge clk);
    chk("R11 reset release", sda_oe, 0);
    rst_n = 1'b1;
    repeat (6) @(negedge clk);
    mon_on = 1'b1;
    exp_quiet = 1'b1;

    // write across the rollover (R8) and a block of ascending data (R4)
    wq = '{8'hA1, 8'hB2, 8'hC3, 8'hD4};
    wr_txn(8'hFD);
    wq = '{8'h11, 8'h22, 8'h33, 8'h44, 8'h55, 8'h66, 8'h77};
    wr_txn(8'h01);

    rd_txn(1'b1, 8'h02, 2, "R6/R7 random sequential data");
    rd_txn(1'b0, 8'h00, 1, "R5 current-address data");
    rd_txn(1'b0, 8'h00, 2, "R5/R7/R10 current sequential data");
    rd_txn(1'b1, 8'hFE, 4, "R8 read rollover data");

    // foreign address then traffic that must be ignored (R3)
    bus_start();
    send_byte({7'h33, 1'b0}, ak); chk("R3 foreign address no ack", ak, 0);
    send_byte(8'h00, ak);         chk("R3 ignored byte no ack", ak, 0);
    send_byte(8'hEE, ak);         chk("R3 ignored data no ack", ak, 0);
    exp_quiet = 1'b0;
    bus_start();
    send_byte({DEV, 1'b1}, ak);   chk("R3 recovers at START", ak, 1);
    recv_byte(1'b0, got);
    chk("R3 pointer and memory untouched", got, mem_m[ptr_m]);
    ptr_m = (ptr_m + 1) % 256;
    exp_quiet = 1'b1;
    bus_stop();
    wait_q();

    // address-only write ended by STOP leaves the pointer loaded (R1, R4)
    wq = '{8'h9A};
    wr_txn(8'h10);
    wq.delete();
    wr_txn(8'h10);
    rd_txn(1'b0, 8'h00, 1, "R1/R4 pointer kept over STOP");
    rd_txn(1'b0, 8'h00, 1, "R5 pointer after single read");

    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

endmodule